// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Loader

This block is the digital front end of a pair of 12-bit converters, modelled on a single system clock. A host drives an 8-bit bus, a 2-bit address and two active-low strobes (select and write). Each channel's 12-bit word is assembled from two byte writes: one fills the low eight code bits and the other fills the top four. The writes land in input registers and do not reach the converters. The bytes may arrive in any order.

A separate active-low load strobe acts on its own, with no gating from select or write. While it is low, both channels' output codes follow their input registers in the same clock. When it rises, both codes freeze. A small state machine watches for a load that overlaps a write. If the load strobe rises less than a set number of cycles after that write ends, it raises a sticky violation flag. Every strobe passes through a two-flop synchronizer before use.

The state machine has three states. `LD_IDLE` means the load strobe is high. `LD_SAFE` means the load is low and no write is pending. `LD_GUARD` means the load is low and a write has overlapped it, so post-write cycles are being counted. The transitions are:
- IDLE→SAFE: load falls while no write is active.
- IDLE→GUARD and SAFE→GUARD: load is low while a write is active.
- GUARD→SAFE: the post-write count reaches the minimum.
- SAFE→IDLE: load rises.
- GUARD→IDLE: load rises, and the violation flag is set.

Top module: `dac_pair_loader`

## Requirements
- R1: A synchronous active-high reset clears both output codes and the violation flag, and all input registers, to zero.
- R2: An input register is written only in a clock where the synchronized select and write strobes are both low; if either is high, no input register changes.
- R3: Address 00 targets channel A low part, 01 channel A high part, 10 channel B low part, 11 channel B high part.
- R4: A low-part write stores bus bits 7:0 as code bits 7:0. A high-part write stores bus bits 3:0 as code bits 11:8 and ignores bus bits 7:4.
- R5: While the load strobe is high, neither output code changes, whatever is written.
- R6: While the load strobe is low, both output codes take their channel's full 12-bit input word in the same clock.
- R7: After the load strobe rises, both codes hold their values until the next low period.
- R8: The load strobe acts independently of select and write. A load with select or write high still updates both codes.
- R9: If a write overlaps a low load strobe and the strobe rises fewer than MIN_HOLD (default 2) clock cycles after the write ends, the violation flag is set. If it rises after MIN_HOLD or more cycles, the flag stays clear.
- R10: The violation flag stays set until reset.
- R11: Each strobe passes through a two-flop synchronizer. With the load strobe held low, a write driven between clock edges changes the output code at the fourth rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Target register select |
| data | input | 8 | Parallel data bus, right-justified |
| ldac_n | input | 1 | Active-low load strobe for both channels |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| load_viol | output | 1 | Sticky flag: load released too soon after an overlapping write |

## Verification
The hardest case to reach is the guard window. A write must overlap a low load strobe, and the strobe must then rise a precise number of cycles after the write strobe returns high. Directed sequences hold the load low, complete a write, and release the load 0, 1, 2 and 3 cycles after the write ends, with a reset before each one. Those sequences check that the flag follows the window boundary and stays set afterwards. Random byte writes with fixed-seed addresses and data, and loads with random select/write levels, cover the double-buffering and the byte packing.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SAFE  = 2'd1,
        LD_GUARD = 2'd2
    } load_state_t;
endpackage

// File: rtl/dpl_sync.sv
module dpl_sync #(
    parameter int WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/dpl_channel.sv
module dpl_channel #(
    parameter int LO_W = 8,
    parameter int HI_W = 4,
    localparam int CODE_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [LO_W-1:0]   lo_data,
    input  logic [HI_W-1:0]   hi_data,
    input  logic              load_en,
    output logic [CODE_W-1:0] in_word,
    output logic [CODE_W-1:0] code
);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (we_lo) lo_q <= lo_data;
            if (we_hi) hi_q <= hi_data;
        end
    end

    assign in_word = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (rst)          code <= '0;
        else if (load_en) code <= in_word;
    end
endmodule

// File: rtl/dpl_load_fsm.sv
module dpl_load_fsm
    import dpl_pkg::*;
#(
    parameter int MIN_HOLD = 2,
    localparam int CNT_W = $clog2(MIN_HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load_low,
    input  logic wr_act,
    output logic load_en,
    output logic viol
);
    load_state_t state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            LD_IDLE: begin
                cnt_nx = '0;
                if (load_low) state_nx = wr_act ? LD_GUARD : LD_SAFE;
            end
            LD_SAFE: begin
                cnt_nx = '0;
                if (!load_low)   state_nx = LD_IDLE;
                else if (wr_act) state_nx = LD_GUARD;
            end
            LD_GUARD: begin
                if (!load_low) begin
                    state_nx = LD_IDLE;
                    cnt_nx   = '0;
                end else if (wr_act) begin
                    cnt_nx = '0;
                end else if (cnt == CNT_W'(MIN_HOLD - 1)) begin
                    state_nx = LD_SAFE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = LD_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                              viol <= 1'b0;
        else if (state == LD_GUARD && !load_low) viol <= 1'b1;
    end

    assign load_en = load_low;
endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader #(
    parameter int BUS_W    = 8,
    parameter int CODE_W   = 12,
    parameter int MIN_HOLD = 2,
    localparam int HI_W    = CODE_W - BUS_W,
    localparam int N_CH    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [BUS_W-1:0]  data,
    input  logic              ldac_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              load_viol
);
    logic cs_s, wr_s, ldac_s;
    logic wr_act, load_en;
    logic [N_CH-1:0][CODE_W-1:0] in_word;
    logic [N_CH-1:0][CODE_W-1:0] code;

    dpl_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({cs_n, wr_n, ldac_n}),
        .sync_out ({cs_s, wr_s, ldac_s})
    );

    assign wr_act = !cs_s && !wr_s;

    dpl_load_fsm #(.MIN_HOLD(MIN_HOLD)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load_low (!ldac_s),
        .wr_act   (wr_act),
        .load_en  (load_en),
        .viol     (load_viol)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic sel;
        assign sel = wr_act && (addr[1] == ch[0]);
        dpl_channel #(.LO_W(BUS_W), .HI_W(HI_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .we_lo   (sel && !addr[0]),
            .we_hi   (sel && addr[0]),
            .lo_data (data),
            .hi_data (data[HI_W-1:0]),
            .load_en (load_en),
            .in_word (in_word[ch]),
            .code    (code[ch])
        );
    end

    assign code_a = code[0];
    assign code_b = code[1];
endmodule

// File: rtl/dpl_checker.sv
module dpl_checker #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_s,
    input logic              wr_s,
    input logic              ldac_s,
    input logic [1:0][CODE_W-1:0] in_word,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic              load_viol
);
    a_r2_no_write: assert property (@(posedge clk) disable iff (rst)
        (cs_s || wr_s) |=> $stable(in_word));

    a_r5_hold_high: assert property (@(posedge clk) disable iff (rst)
        ldac_s |=> ($stable(code_a) && $stable(code_b)));

    a_r6_follow_low: assert property (@(posedge clk) disable iff (rst)
        !ldac_s |=> (code_a == $past(in_word[0]) && code_b == $past(in_word[1])));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        load_viol |=> load_viol);

    a_r9_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(load_viol) |-> $past(ldac_s));
endmodule

bind dac_pair_loader dpl_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (cs_s),
    .wr_s      (wr_s),
    .ldac_s    (ldac_s),
    .in_word   (in_word),
    .code_a    (code_a),
    .code_b    (code_b),
    .load_viol (load_viol)
);

// File: tb/dac_pair_loader_test.sv
`timescale 1ns/1ps
module dac_pair_loader_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  data = '0;
    logic [11:0] code_a, code_b;
    logic        load_viol;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] m_lo [2];
    logic [3:0] m_hi [2];
    logic [11:0] exp_a, exp_b;

    always #5 clk = ~clk;

    dac_pair_loader uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .data(data), .ldac_n(ldac_n), .code_a(code_a), .code_b(code_b),
        .load_viol(load_viol)
    );

    function automatic logic [11:0] word_of(int ch);
        return {m_hi[ch], m_lo[ch]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; ldac_n = 1'b1;
        tick(3);
        rst = 1'b0;
        for (int c = 0; c < 2; c++) begin m_lo[c] = '0; m_hi[c] = '0; end
        exp_a = '0; exp_b = '0;
        tick(1);
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        addr = a; data = d; cs_n = 1'b0; wr_n = 1'b0;
        tick(3);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(3);
        if (a[0]) m_hi[a[1]] = d[3:0];
        else      m_lo[a[1]] = d;
    endtask

    task automatic bus_load(logic c_lvl, logic w_lvl);
        cs_n = c_lvl; wr_n = w_lvl; ldac_n = 1'b0;
        tick(4);
        ldac_n = 1'b1;
        tick(4);
        cs_n = 1'b1; wr_n = 1'b1;
        exp_a = word_of(0); exp_b = word_of(1);
    endtask

    task automatic overlap(int gap);
        do_reset();
        ldac_n = 1'b0;
        tick(3);
        addr = 2'b00; data = 8'h5a; cs_n = 1'b0; wr_n = 1'b0;
        tick(3);
        cs_n = 1'b1; wr_n = 1'b1;
        if (gap > 0) tick(gap);
        ldac_n = 1'b1;
        tick(5);
        chk($sformatf("R9 gap=%0d", gap), load_viol, (gap < 2) ? 1 : 0);
    endtask

    initial begin
        void'($urandom(32'h1d2c));
        do_reset();
        chk("R1 code_a", code_a, 0);
        chk("R1 code_b", code_b, 0);
        chk("R1 viol", load_viol, 0);

        // R3/R4 directed: each address, high nibble ignored
        bus_write(2'b00, 8'h3c);
        bus_write(2'b01, 8'hf7);
        bus_write(2'b10, 8'hc5);
        bus_write(2'b11, 8'h92);
        chk("R5 no load yet a", code_a, 0);
        chk("R5 no load yet b", code_b, 0);
        bus_load(1'b1, 1'b1);
        chk("R3 R4 code_a", code_a, 12'h73c);
        chk("R3 R4 code_b", code_b, 12'h2c5);

        // R2: strobes alone do not write
        addr = 2'b00; data = 8'hff; cs_n = 1'b0; wr_n = 1'b1; tick(4);
        cs_n = 1'b1; wr_n = 1'b0; tick(4); wr_n = 1'b1; tick(3);
        bus_load(1'b1, 1'b1);
        chk("R2 code_a", code_a, 12'h73c);

        // R8: load with select low but write high
        bus_write(2'b10, 8'h11);
        bus_load(1'b0, 1'b1);
        chk("R8 code_b", code_b, 12'h211);
        chk("R8 code_a", code_a, 12'h73c);

        // random traffic
        for (int it = 0; it < 40; it++) begin
            int nw = 1 + ($urandom % 4);
            for (int k = 0; k < nw; k++)
                bus_write(2'($urandom), 8'($urandom));
            chk("R5 a", code_a, exp_a);
            chk("R5 b", code_b, exp_b);
            begin
                logic c = 1'($urandom);
                logic w = c ? 1'($urandom) : 1'b1;
                bus_load(c, w);
            end
            chk("R6 a", code_a, exp_a);
            chk("R6 b", code_b, exp_b);
            bus_write(2'($urandom), 8'($urandom));
            chk("R7 a", code_a, exp_a);
            chk("R7 b", code_b, exp_b);
        end

        // R11 latency with load held low
        do_reset();
        ldac_n = 1'b0; tick(4);
        addr = 2'b00; data = 8'ha6; cs_n = 1'b0; wr_n = 1'b0;
        tick(3);
        chk("R11 before", code_a, 0);
        tick(1);
        chk("R11 after", code_a, 12'h0a6);
        cs_n = 1'b1; wr_n = 1'b1; tick(4);
        ldac_n = 1'b1; tick(4);
        chk("R9 clean release", load_viol, 0);

        // R9 guard window
        overlap(0);
        overlap(1);
        overlap(2);
        overlap(3);

        // R10 sticky across a later clean load
        overlap(0);
        bus_load(1'b1, 1'b1);
        tick(3);
        chk("R10 sticky", load_viol, 1);
        do_reset();
        chk("R1 viol cleared", load_viol, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule